// File: doc/BRIEF.md
# Bit-Serial Associative Word Array

This block is a row of identical word cells that act as a single-instruction, multiple-data machine. Each cell holds a column of local bit storage, a one-bit result accumulator, a per-cell carry flip-flop and a write mask. Every cell receives the same four-bit opcode and the same bit address in each cycle, but works only on its own stored bit. A vector element lies at the same bit position in every word, so multi-bit work proceeds one column at a time, with the most significant column first when a maximum is searched for.

The write mask in each cell is loaded from a stored column. When a cell's mask bit is clear, stores into that cell's storage are suppressed. This lets a vector shorter than the array, or a set of words chosen by an earlier comparison, be updated selectively. A responder classifier combines the accumulators of all cells into one of three outcomes: none, exactly one, or more than one. A sequencer outside the block uses that outcome to steer searches. The block has no control state machine: every opcode completes in one clock edge. An external column input lets a whole column be written in parallel under the mask, and the column at the current address is always visible on the read-back port.

Top module: `assoc_word_array`

## Requirements
- R1: While reset is low, every accumulator and carry is cleared, every write mask is set and all storage is zero. As a result, responder status reads 2'b00 and read-back reads zero.
- R2: Opcode PUT (4'hB) writes bit i of `col_in` into column `addr` of each cell i whose mask is set. Read-back of that column shows the new value after that edge.
- R3: LOAD (4'h1) copies the stored bit at `addr` into the accumulator. LOAD-complement (4'h2) copies its inverse.
- R4: AND (4'h3), OR (4'h4) and XOR (4'h5) combine the accumulator with the stored bit at `addr` and leave the result in the accumulator.
- R5: ADD (4'h6) sets the accumulator to accumulator XOR stored bit XOR carry, and sets the carry to the majority of those three. SET-CARRY (4'hA) loads every carry with `const_bit`.
- R6: STORE (4'h7) writes the accumulator into column `addr`, and STORE-complement (4'h8) writes its inverse, in masked-in cells only. No opcode other than STORE, STORE-complement and PUT changes any stored bit.
- R7: LOAD-MASK (4'h9) loads each cell's write mask from its stored bit at `addr`. A cell with a cleared mask keeps its stored bit on STORE, STORE-complement and PUT.
- R8: While `ce` is low, no accumulator, carry, mask or stored bit changes.
- R9: `resp` is 2'b00 when no accumulator is one, 2'b01 when exactly one is one and 2'b10 when two or more are one. It reflects the accumulators written at the previous edge, and 2'b11 never appears.
- R10: A most-significant-first search (load candidates, AND with the column, keep the result only when `resp` is not 2'b00) leaves ones exactly in the words that hold the largest value.
- R11: NOP (4'h0) and the unused codes 4'hC to 4'hF change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Global enable; no state changes while low |
| op | input | 4 | Shared opcode for all cells |
| addr | input | AW | Shared bit address into every cell's storage |
| const_bit | input | 1 | Shared constant bit used by SET-CARRY |
| col_in | input | N | One bit per cell, written by PUT |
| resp | output | 2 | Responder class: none, one or many |
| rd_col | output | N | Stored column at `addr`, one bit per cell |

## Verification
The logic opcodes are tried on overlapping columns (00F0 against 0FF0), so AND, OR and XOR each give a different answer and a swapped operator shows up. The adder is tried with carry set, carry propagated from the previous bit, and carry cleared; this separates the sum term from the majority term. Mask tests use a partial mask, so suppressed cells can be told apart from written ones. A maximum search over values with a tied winner checks that the responder classifier tells one responder from many.

// File: rtl/assoc_array_pkg.sv
package assoc_array_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LD    = 4'h1,
        OP_LDN   = 4'h2,
        OP_AND   = 4'h3,
        OP_OR    = 4'h4,
        OP_XOR   = 4'h5,
        OP_ADD   = 4'h6,
        OP_ST    = 4'h7,
        OP_STN   = 4'h8,
        OP_LDMSK = 4'h9,
        OP_SETC  = 4'hA,
        OP_PUT   = 4'hB
    } op_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_ONE  = 2'b01,
        RSP_MANY = 2'b10
    } resp_e;

endpackage

// File: rtl/word_cell.sv
module word_cell
    import assoc_array_pkg::*;
#(
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  op_e           opc,
    input  logic [AW-1:0] addr,
    input  logic          k,
    input  logic          ext_bit,
    output logic          rd_bit,
    output logic          acc
);

    logic [DEPTH-1:0] store_q;
    logic             acc_q;
    logic             cy_q;
    logic             msk_q;
    logic             d;

    assign d      = store_q[addr];
    assign rd_bit = d;
    assign acc    = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
            acc_q   <= 1'b0;
            cy_q    <= 1'b0;
            msk_q   <= 1'b1;
        end else if (ce) begin
            unique case (opc)
                OP_LD:    acc_q <= d;
                OP_LDN:   acc_q <= ~d;
                OP_AND:   acc_q <= acc_q & d;
                OP_OR:    acc_q <= acc_q | d;
                OP_XOR:   acc_q <= acc_q ^ d;
                OP_ADD: begin
                    acc_q <= acc_q ^ d ^ cy_q;
                    cy_q  <= (acc_q & d) | (cy_q & (acc_q | d));
                end
                OP_ST:    if (msk_q) store_q[addr] <= acc_q;
                OP_STN:   if (msk_q) store_q[addr] <= ~acc_q;
                OP_PUT:   if (msk_q) store_q[addr] <= ext_bit;
                OP_LDMSK: msk_q <= d;
                OP_SETC:  cy_q  <= k;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/responder_classifier.sv
module responder_classifier
    import assoc_array_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] acc_vec,
    output resp_e        cls
);

    logic any_set;
    logic multi_set;

    assign any_set   = |acc_vec;
    // clearing the lowest set bit leaves something only if two or more were set
    assign multi_set = |(acc_vec & (acc_vec - N'(1)));

    always_comb begin
        if (multi_set)    cls = RSP_MANY;
        else if (any_set) cls = RSP_ONE;
        else              cls = RSP_NONE;
    end

endmodule

// File: rtl/assoc_word_array.sv
module assoc_word_array
    import assoc_array_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [3:0]    op,
    input  logic [AW-1:0] addr,
    input  logic          const_bit,
    input  logic [N-1:0]  col_in,
    output logic [1:0]    resp,
    output logic [N-1:0]  rd_col
);

    op_e          opc;
    logic [N-1:0] acc_vec;
    resp_e        cls;

    assign opc  = op_e'(op);
    assign resp = cls;

    for (genvar i = 0; i < N; i++) begin : g_cell
        word_cell #(.AW(AW)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (ce),
            .opc     (opc),
            .addr    (addr),
            .k       (const_bit),
            .ext_bit (col_in[i]),
            .rd_bit  (rd_col[i]),
            .acc     (acc_vec[i])
        );
    end

    responder_classifier #(.N(N)) u_resp (
        .acc_vec (acc_vec),
        .cls     (cls)
    );

endmodule

// File: rtl/assoc_word_array_chk.sv
module assoc_word_array_chk #(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic [3:0]    op,
    input logic [AW-1:0] addr,
    input logic [1:0]    resp,
    input logic [N-1:0]  rd_col
);

    logic is_write;
    logic is_unused;
    assign is_write  = (op == 4'h7) || (op == 4'h8) || (op == 4'hB);
    assign is_unused = (op == 4'h0) || (op >= 4'hC);

    // R9
    resp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp != 2'b11);

    // R8
    hold_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce) ##1 $stable(addr) |-> $stable(rd_col));

    // R8
    hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(resp));

    // R6
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !is_write) ##1 $stable(addr) |-> $stable(rd_col));

    // R11
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && is_unused) |=> $stable(resp));

endmodule

bind assoc_word_array assoc_word_array_chk #(.N(N), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .op     (op),
    .addr   (addr),
    .resp   (resp),
    .rd_col (rd_col)
);

// File: tb/assoc_word_array_test.sv
module assoc_word_array_test;
    import assoc_array_pkg::*;

    localparam int N  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b1;
    logic [3:0]    op = 4'h0;
    logic [AW-1:0] addr = '0;
    logic          const_bit = 1'b0;
    logic [N-1:0]  col_in = '0;
    logic [1:0]    resp;
    logic [N-1:0]  rd_col;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assoc_word_array #(.N(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .op(op), .addr(addr),
        .const_bit(const_bit), .col_in(col_in), .resp(resp), .rd_col(rd_col)
    );

    typedef struct packed {
        logic [3:0]    o;
        logic [AW-1:0] a;
        logic          k;
        logic [N-1:0]  c;
        logic [N-1:0]  xrd;
        logic [1:0]    xrs;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{4'hB, 4'd0,  1'b0, 16'h00F0, 16'h00F0, 2'b00}, // R2
        '{4'hB, 4'd1,  1'b0, 16'h0FF0, 16'h0FF0, 2'b00}, // R2
        '{4'h1, 4'd0,  1'b0, 16'h0000, 16'h00F0, 2'b10}, // R3
        '{4'h3, 4'd1,  1'b0, 16'h0000, 16'h0FF0, 2'b10}, // R4 acc=00F0
        '{4'h5, 4'd1,  1'b0, 16'h0000, 16'h0FF0, 2'b10}, // R4 acc=0F00
        '{4'h7, 4'd2,  1'b0, 16'h0000, 16'h0F00, 2'b10}, // R6
        '{4'h8, 4'd3,  1'b0, 16'h0000, 16'hF0FF, 2'b10}, // R6
        '{4'h2, 4'd3,  1'b0, 16'h0000, 16'hF0FF, 2'b10}, // R3 acc=0F00
        '{4'h4, 4'd0,  1'b0, 16'h0000, 16'h00F0, 2'b10}, // R4 acc=0FF0
        '{4'h7, 4'd13, 1'b0, 16'h0000, 16'h0FF0, 2'b10}, // R4
        '{4'hB, 4'd4,  1'b0, 16'h0010, 16'h0010, 2'b10}, // R2
        '{4'h1, 4'd4,  1'b0, 16'h0000, 16'h0010, 2'b01}, // R9 one
        '{4'h1, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b00}, // R9 none
        '{4'h2, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b10}, // R3 acc=FFFF
        '{4'h7, 4'd10, 1'b0, 16'h0000, 16'hFFFF, 2'b10}, // R6
        '{4'hA, 4'd5,  1'b1, 16'h0000, 16'h0000, 2'b10}, // R5 carry=1
        '{4'h1, 4'd0,  1'b0, 16'h0000, 16'h00F0, 2'b10}, // R3
        '{4'h6, 4'd1,  1'b0, 16'h0000, 16'h0FF0, 2'b10}, // R5 acc=F0FF
        '{4'h7, 4'd6,  1'b0, 16'h0000, 16'hF0FF, 2'b10}, // R5 sum
        '{4'h1, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b00}, // R3
        '{4'h6, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b10}, // R5 carry out 0FF0
        '{4'h7, 4'd7,  1'b0, 16'h0000, 16'h0FF0, 2'b10}, // R5 carry
        '{4'hA, 4'd5,  1'b1, 16'h0000, 16'h0000, 2'b10}, // R5
        '{4'hA, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b10}, // R5 carry=0
        '{4'h1, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b00}, // R3
        '{4'h6, 4'd5,  1'b0, 16'h0000, 16'h0000, 2'b00}, // R5 cleared carry
        '{4'h9, 4'd1,  1'b0, 16'h0000, 16'h0FF0, 2'b00}, // R7 mask=0FF0
        '{4'h1, 4'd3,  1'b0, 16'h0000, 16'hF0FF, 2'b10}, // R3
        '{4'h7, 4'd2,  1'b0, 16'h0000, 16'h00F0, 2'b10}, // R7 masked store
        '{4'hB, 4'd9,  1'b0, 16'hFFFF, 16'h0FF0, 2'b10}, // R7 masked put
        '{4'hF, 4'd9,  1'b1, 16'hFFFF, 16'h0FF0, 2'b10}, // R11 unused code
        '{4'h0, 4'd2,  1'b1, 16'hFFFF, 16'h00F0, 2'b10}, // R11 nop
        '{4'h9, 4'd10, 1'b0, 16'h0000, 16'hFFFF, 2'b10}, // R7 mask=FFFF
        '{4'hB, 4'd9,  1'b0, 16'hFFFF, 16'hFFFF, 2'b10}  // R7 restored
    };

    task automatic check(input string req, input logic [N-1:0] xrd, input logic [1:0] xrs);
        n_vec++;
        if (rd_col !== xrd || resp !== xrs) begin
            n_bad++;
            $display("FAIL %s: rd_col=%h resp=%b expected rd_col=%h resp=%b",
                     req, rd_col, resp, xrd, xrs);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [AW-1:0] a,
                        input logic k, input logic [N-1:0] c);
        op = o; addr = a; const_bit = k; col_in = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] win;
        int vals [N];
        int best;
        int nwin;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", '0, 2'b00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].o, VEC[i].a, VEC[i].k, VEC[i].c);
            check($sformatf("table row %0d", i), VEC[i].xrd, VEC[i].xrs);
        end

        // R8: global enable low freezes storage and accumulators
        ce = 1'b0;
        step(4'hB, 4'd9, 1'b0, 16'h0000);
        check("R8 put blocked", 16'hFFFF, 2'b10);
        step(4'h1, 4'd5, 1'b0, 16'h0000);
        check("R8 load blocked", 16'h0000, 2'b10);
        ce = 1'b1;

        // R10: maximum search, bit 3 in column 15 down to bit 0 in column 12
        best = 0;
        for (int i = 0; i < N; i++) begin
            vals[i] = (i * 5) % 11;
            if (vals[i] > best) best = vals[i];
        end
        win = '0; nwin = 0;
        for (int i = 0; i < N; i++) if (vals[i] == best) begin win[i] = 1'b1; nwin++; end
        for (int b = 0; b < 4; b++) begin
            logic [N-1:0] colv;
            for (int i = 0; i < N; i++) colv[i] = vals[i][b];
            step(4'hB, AW'(12 + b), 1'b0, colv);
        end
        step(4'hB, 4'd11, 1'b0, 16'hFFFF);
        for (int b = 3; b >= 0; b--) begin
            step(4'h1, 4'd11, 1'b0, '0);
            step(4'h3, AW'(12 + b), 1'b0, '0);
            if (resp != 2'b00) step(4'h7, 4'd11, 1'b0, '0);
        end
        step(4'h1, 4'd11, 1'b0, '0);
        check("R10 max search", win, (nwin > 1) ? 2'b10 : 2'b01);

        // R1: reset in mid-run clears storage and accumulators
        rst_n = 1'b0;
        step(4'h0, 4'd11, 1'b0, '0);
        check("R1 reset mid-run", '0, 2'b00);
        rst_n = 1'b1;
        step(4'hB, 4'd3, 1'b0, 16'hFFFF);
        check("R1 mask set after reset", 16'hFFFF, 2'b00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule